// File: doc/BRIEF.md
# Debug Port Lock Controller

This block decides whether a debug port gets the full instruction set or only a small restricted set. When the brownout reset is released, it samples two 16-bit signature words once and decodes them into a lock mode. The three modes are open, locked with no way to unlock, and locked with a password. After that sample, the signature inputs are ignored until the next brownout reset.

In password mode, the second signature gives the password length in words. The stored password lives at a fixed base address, with one word every two bytes. An unlock attempt starts when a fixed two-word pattern newly appears on the two incoming mailbox words. The block then fetches each stored word through a request/valid read port with variable latency. It compares each stored word against the entered word offered on the key input. If every word matches, the block grants full access until the next brownout reset. The block drives a full-access flag and decides whether the current instruction code is permitted.

Top module: `dbg_lock_ctrl`

## Requirements
- R1: Signatures sig_a = 16'h5555 and sig_b = 16'h5555 select the no-password lock. In this mode full_access stays 0 and no mailbox pattern issues a memory read or grants access.
- R2: sig_a = 16'hAAAA with sig_b other than 16'h5555 selects the password lock, and sig_b is then the password length in 16-bit words.
- R3: Any other signature pair leaves the port open, so full_access is 1 from the first clock edge after reset release. While reset is held, full_access is 0.
- R4: Signatures are sampled only at the first clock edge after rst_n rises. Later changes on sig_a or sig_b do not change full_access until the next reset.
- R5: Password word i is read from byte address 16'hFF88 + 2*i. mem_req stays high and mem_addr stays stable until mem_valid is seen.
- R6: A check starts only when mbox_in0 = 16'hA55A and mbox_in1 = 16'h1E1E appear after a cycle in which that pair was not present. A pattern that stays present does not start a second check.
- R7: When all entered words match the stored words, full_access rises and stays 1 until the next reset, even if a later attempt uses a wrong password.
- R8: The first mismatching word ends the check without granting access. A new check needs the mailbox pattern to be removed and presented again.
- R9: A password length of zero never grants access and issues no memory read.
- R10: When full_access is 0, ir_allowed is 1 only for ir_code 8'hFF (bypass) and 8'h61 (mailbox exchange). When full_access is 1, every code is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low brownout reset, asynchronous assert |
| sig_a | input | 16 | Signature word 1 |
| sig_b | input | 16 | Signature word 2 (password length in password mode) |
| mbox_in0 | input | 16 | Incoming mailbox word 0 |
| mbox_in1 | input | 16 | Incoming mailbox word 1 |
| key_valid | input | 1 | Entered password word is present |
| key_word | input | 16 | Entered password word for the current index |
| mem_req | output | 1 | Stored-password read request |
| mem_addr | output | 16 | Byte address of the stored word |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| ir_code | input | 8 | Current debug instruction code |
| ir_allowed | output | 1 | Instruction permitted |
| full_access | output | 1 | Full instruction set granted |

## Verification
The decoded mode appears on full_access one clock edge after rst_n rises. The bench therefore releases reset on a falling edge and reads the flag on the next falling edge. A password check takes a number of cycles that depends on the length and on the memory latency. The bench waits a fixed window that is longer than the worst case for the lengths and latencies it uses, and only then samples full_access. A monitor checks on every request cycle that the address stays stable and records the highest address read. ir_allowed is combinational, so it is sampled half a cycle after each new code is driven.

// File: rtl/dbg_lock_ctrl.sv
module dbg_lock_ctrl #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int IRW = 8,
  parameter logic [AW-1:0] PW_BASE = 16'hFF88,
  parameter logic [DW-1:0] SIG_NOPW = 16'h5555,
  parameter logic [DW-1:0] SIG_PWD = 16'hAAAA,
  parameter logic [DW-1:0] MAGIC0 = 16'hA55A,
  parameter logic [DW-1:0] MAGIC1 = 16'h1E1E,
  parameter logic [IRW-1:0] IR_BYPASS = 8'hFF,
  parameter logic [IRW-1:0] IR_MBX = 8'h61
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  sig_a,
  input  logic [DW-1:0]  sig_b,
  input  logic [DW-1:0]  mbox_in0,
  input  logic [DW-1:0]  mbox_in1,
  input  logic           key_valid,
  input  logic [DW-1:0]  key_word,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_valid,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [IRW-1:0] ir_code,
  output logic           ir_allowed,
  output logic           full_access
);
  localparam int SHIFT = $clog2(DW / 8);

  typedef enum logic [1:0] {MD_PEND, MD_OPEN, MD_NOPW, MD_PWD} mode_t;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CMP, ST_DONE} state_t;

  mode_t   mode_q, mode_d;
  state_t  st_q;
  logic [DW-1:0] len_q, ptr_q, word_q;
  logic    magic, magic_q, start;

  always_comb begin
    if (sig_a == SIG_NOPW && sig_b == SIG_NOPW) mode_d = MD_NOPW;
    else if (sig_a == SIG_PWD && sig_b != SIG_NOPW) mode_d = MD_PWD;
    else mode_d = MD_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= MD_PEND;
      len_q  <= '0;
    end else if (mode_q == MD_PEND) begin
      mode_q <= mode_d;
      len_q  <= sig_b;
    end

  assign magic = (mbox_in0 == MAGIC0) && (mbox_in1 == MAGIC1);
  assign start = magic && !magic_q && st_q == ST_IDLE && mode_q == MD_PWD;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      word_q  <= '0;
      magic_q <= 1'b0;
    end else begin
      magic_q <= magic;
      case (st_q)
        ST_IDLE: if (start && len_q != '0) begin
          ptr_q <= '0;
          st_q  <= ST_FETCH;
        end
        ST_FETCH: if (mem_valid) begin
          word_q <= mem_rdata;
          st_q   <= ST_CMP;
        end
        ST_CMP: if (key_valid) begin
          if (key_word != word_q) st_q <= ST_IDLE;
          else if (ptr_q == len_q - 1'b1) st_q <= ST_DONE;
          else begin
            ptr_q <= ptr_q + 1'b1;
            st_q  <= ST_FETCH;
          end
        end
        default: st_q <= ST_DONE;
      endcase
    end

  assign mem_req     = st_q == ST_FETCH;
  assign mem_addr    = PW_BASE + (AW'(ptr_q) << SHIFT);
  assign full_access = mode_q == MD_OPEN || st_q == ST_DONE;
  assign ir_allowed  = full_access || ir_code == IR_BYPASS || ir_code == IR_MBX;

  // R1
  nopw_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MD_NOPW |-> !full_access && !mem_req);
  // R4
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != MD_PEND |=> $stable(mode_q) && $stable(len_q));
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));
  // R7
  grant_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_access |=> full_access);
  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MD_PWD && len_q == '0 |-> !full_access && !mem_req);
  // R2
  req_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mode_q == MD_PWD);
endmodule

// File: tb/dbg_lock_ctrl_bench.sv
module dbg_lock_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] sig_a = '0, sig_b = '0, mbox_in0 = '0, mbox_in1 = '0;
  logic key_valid = 1'b1;
  logic [15:0] key_word, mem_rdata, mem_addr;
  logic mem_req, mem_valid, ir_allowed, full_access;
  logic [7:0] ir_code = '0;

  int nchk = 0, nfail = 0, lat = 0, bad_idx = -1;
  int req_cnt = 0, addr_err = 0, vcnt = 0;
  logic [15:0] max_addr = '0, prev_addr = '0;
  logic prev_wait = 1'b0, vld_q = 1'b0;

  always #4 clk = ~clk;

  dbg_lock_ctrl u_dbg_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .sig_a(sig_a), .sig_b(sig_b),
    .mbox_in0(mbox_in0), .mbox_in1(mbox_in1), .key_valid(key_valid),
    .key_word(key_word), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .ir_code(ir_code),
    .ir_allowed(ir_allowed), .full_access(full_access));

  function automatic logic [15:0] stored(input int i);
    return 16'h1000 + 16'(i) * 16'h0111;
  endfunction

  int idx;
  always_comb begin
    idx = int'((mem_addr - 16'hFF88) >> 1);
    mem_rdata = stored(idx);
    key_word = stored(idx) ^ ((idx == bad_idx) ? 16'h0001 : 16'h0000);
  end
  assign mem_valid = vld_q;

  always @(posedge clk) begin
    if (!mem_req || vld_q) begin vld_q <= 1'b0; vcnt <= 0; end
    else if (vcnt >= lat) vld_q <= 1'b1;
    else vcnt <= vcnt + 1;
    if (rst_n && mem_req) begin
      req_cnt <= req_cnt + 1;
      if (mem_addr < 16'hFF88 || mem_addr[0]) addr_err <= addr_err + 1;
      if (prev_wait && mem_addr != prev_addr) addr_err <= addr_err + 1;
      if (mem_addr > max_addr) max_addr <= mem_addr;
    end
    prev_wait <= mem_req && !mem_valid;
    prev_addr <= mem_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    rst_n = 1'b0; sig_a = a; sig_b = b;
    mbox_in0 = '0; mbox_in1 = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req_cnt = 0; max_addr = '0;
  endtask

  task automatic attempt(input int bad, input bit drop);
    bad_idx = bad;
    mbox_in0 = 16'hA55A; mbox_in1 = 16'h1E1E;
    repeat (80) @(negedge clk);
    if (drop) begin
      mbox_in0 = '0; mbox_in1 = '0;
      @(negedge clk);
    end
  endtask

  localparam logic [32:0] VEC [6] = '{
    {16'h5555, 16'h5555, 1'b0},
    {16'hAAAA, 16'h0003, 1'b0},
    {16'hAAAA, 16'h5555, 1'b1},
    {16'h5555, 16'hAAAA, 1'b1},
    {16'h1234, 16'h5678, 1'b1},
    {16'hAAAA, 16'h0000, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R3 reset state full_access", {31'd0, full_access}, 32'd0);
    ir_code = 8'h00; #1;
    chk("R10 reset filter blocks", {31'd0, ir_allowed}, 32'd0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      do_reset(VEC[i][32:17], VEC[i][16:1]);
      chk($sformatf("R1 R2 R3 decode vector %0d", i), {31'd0, full_access}, {31'd0, VEC[i][0]});
    end

    // R4: signatures changed after release are ignored
    do_reset(16'hAAAA, 16'h0003);
    sig_a = 16'h0000; sig_b = 16'h0000;
    repeat (5) @(negedge clk);
    chk("R4 late signature ignored", {31'd0, full_access}, 32'd0);
    do_reset(16'h0000, 16'h0000);
    chk("R4 new signature after reset", {31'd0, full_access}, 32'd1);
    ir_code = 8'h00; #1;
    chk("R10 open allows any code", {31'd0, ir_allowed}, 32'd1);

    // R10 and R1
    do_reset(16'h5555, 16'h5555);
    ir_code = 8'hFF; #1; chk("R10 bypass allowed", {31'd0, ir_allowed}, 32'd1);
    ir_code = 8'h61; #1; chk("R10 mailbox allowed", {31'd0, ir_allowed}, 32'd1);
    ir_code = 8'h3C; #1; chk("R10 other blocked", {31'd0, ir_allowed}, 32'd0);
    attempt(-1, 1'b1);
    chk("R1 no-password lock ignores mailbox", {31'd0, full_access}, 32'd0);
    chk("R1 no memory reads", req_cnt, 32'd0);

    // R5, R7: correct password, latency 3
    lat = 3;
    do_reset(16'hAAAA, 16'h0003);
    attempt(-1, 1'b1);
    chk("R7 correct password grants", {31'd0, full_access}, 32'd1);
    chk("R5 last address", {16'd0, max_addr}, 32'h0000FF8C);
    chk("R5 address stable and aligned", addr_err, 32'd0);
    attempt(0, 1'b1);
    chk("R7 wrong password keeps grant", {31'd0, full_access}, 32'd1);

    // R8, R6: mismatch then retry, latency 0
    lat = 0;
    do_reset(16'hAAAA, 16'h0004);
    attempt(2, 1'b0);
    chk("R8 mismatch keeps lock", {31'd0, full_access}, 32'd0);
    bad_idx = -1;
    repeat (80) @(negedge clk);
    chk("R6 held pattern does not retrigger", {31'd0, full_access}, 32'd0);
    mbox_in0 = '0; mbox_in1 = '0;
    @(negedge clk);
    chk("R6 no trigger without pattern", {31'd0, full_access}, 32'd0);
    attempt(-1, 1'b1);
    chk("R8 retry after re-present grants", {31'd0, full_access}, 32'd1);
    chk("R5 four-word last address", {16'd0, max_addr}, 32'h0000FF8E);

    // R9
    do_reset(16'hAAAA, 16'h0000);
    attempt(-1, 1'b1);
    chk("R9 zero length stays locked", {31'd0, full_access}, 32'd0);
    chk("R9 zero length no reads", req_cnt, 32'd0);

    // R2: length one
    do_reset(16'hAAAA, 16'h0001);
    attempt(-1, 1'b1);
    chk("R2 one-word password grants", {31'd0, full_access}, 32'd1);
    chk("R2 one read only", {16'd0, max_addr}, 32'h0000FF88);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule